// File: doc/BRIEF.md
# Block Memory Mapper with Protection

This block sits in the access path of an in-circuit emulator. It splits the 16-bit target address space into 64 blocks of 1024 bytes each. For every block, a map entry that software loads decides three things. The first is whether the block lives in the prototype's own memory or in emulator memory. The second is whether the block exists at all. The third is whether writes to it are allowed. An entry also carries a 6-bit block number, which moves a block that resides in emulator memory to another block position there.

Each access is described by a valid flag, a write flag and an address. From these and the map, the block produces combinationally:
- a select for target memory and a select for emulator memory;
- the physical address;
- a write-inhibit;
- a break request;
- the read data seen by the emulated processor.

Blocks marked write-protected let software behave as read-only memory while it is debugged. Writes to those blocks are always suppressed, and they raise a break only when the break-on-write option is enabled. Any access to a block marked absent raises a break.

Top module: `blk_mapper`

## Requirements
- R1: After reset, every entry is target-resident, existent and unprotected, and its translation is the identity. Any valid access then asserts `sel_tgt_o` only, with `phys_addr_o` equal to `acc_addr_i`.
- R2: The block index is `acc_addr_i[15:10]`. A write on the map port stores the entry at `map_idx_i` at the next rising clock edge, and no other entry changes.
- R3: For a valid access to an emulator-resident, existent block, `sel_emu_o`=1 and `sel_tgt_o`=0. `phys_addr_o` is {translated block, `acc_addr_i[9:0]`}.
- R4: For a valid access to a target-resident, existent block, `sel_tgt_o`=1 and `sel_emu_o`=0. `phys_addr_o` equals `acc_addr_i`.
- R5: For a valid access to an absent block, both selects are 0 and `brk_o`=1, for reads and writes alike. A read returns 8'hFF, and a write asserts `wr_inhibit_o`. The absent mark overrides the write-protect mark.
- R6: A write to an existent, write-protected block asserts `wr_inhibit_o` and keeps its select. `brk_o` then equals `brk_on_wr_i`.
- R7: A read from an existent, write-protected block behaves as an unprotected read: no inhibit, no break.
- R8: With `acc_valid_i`=0, all of `sel_tgt_o`, `sel_emu_o`, `wr_inhibit_o` and `brk_o` are 0.
- R9: For a read, `rdata_o` comes from `emu_rdata_i` when the block is emulator-resident and from `tgt_rdata_i` when it is target-resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_we_i | input | 1 | Map entry write strobe |
| map_idx_i | input | 6 | Entry index to write |
| map_emu_i | input | 1 | 1: block resides in emulator memory |
| map_absent_i | input | 1 | 1: block is non-existent |
| map_wprot_i | input | 1 | 1: block is write-protected |
| map_xlat_i | input | 6 | Translated block number in emulator memory |
| brk_on_wr_i | input | 1 | Break on a write to a protected block |
| acc_valid_i | input | 1 | Access in progress |
| acc_wr_i | input | 1 | 1: write, 0: read |
| acc_addr_i | input | 16 | Target address |
| emu_rdata_i | input | 8 | Read data from emulator memory |
| tgt_rdata_i | input | 8 | Read data from target memory |
| sel_tgt_o | output | 1 | Target memory select |
| sel_emu_o | output | 1 | Emulator memory select |
| phys_addr_o | output | 16 | Physical address |
| wr_inhibit_o | output | 1 | Suppress the write |
| brk_o | output | 1 | Break request |
| rdata_o | output | 8 | Read data to the processor |

## Verification
The bench first sweeps all 64 blocks on the reset map. A reset value left unset would show up there as a wrong select or a moved address. It then writes one entry alone and checks both of its neighbours. An index decode that spills over would change a block that was never written.

Next the whole map is loaded with a computed pattern that mixes residence, absence, protection and translation, including blocks that are both absent and protected. Every block is read and written with the break-on-write option off and on. This exposes the likely faults:
- a protected write that lands in memory, or that breaks with the option off;
- an absent block that still drives a select or returns live data;
- a translation that replaces the wrong address bits.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int BLK_W = 6;
  localparam int OFF_W = 10;
  localparam int ADDR_W = BLK_W + OFF_W;
  localparam int N_BLK = 1 << BLK_W;

  typedef struct packed {
    logic             emu;
    logic             absent;
    logic             wprot;
    logic [BLK_W-1:0] xlat;
  } map_ent_t;
endpackage

// File: rtl/map_store.sv
module map_store
  import mapper_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [BLK_W-1:0] wr_idx_i,
  input  map_ent_t         wr_ent_i,
  input  logic [BLK_W-1:0] rd_idx_i,
  output map_ent_t         rd_ent_o
);
  map_ent_t tbl_q [N_BLK];

  for (genvar i = 0; i < N_BLK; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl_q[i] <= '{emu: 1'b0, absent: 1'b0, wprot: 1'b0, xlat: BLK_W'(i)};
      end else if (we_i && wr_idx_i == BLK_W'(i)) begin
        tbl_q[i] <= wr_ent_i;
      end
    end
  end

  assign rd_ent_o = tbl_q[rd_idx_i];
endmodule

// File: rtl/map_check.sv
module map_check
  import mapper_pkg::*;
(
  input  map_ent_t          ent_i,
  input  logic              valid_i,
  input  logic              wr_i,
  input  logic              brk_on_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_tgt_o,
  output logic              sel_emu_o,
  output logic [ADDR_W-1:0] phys_o,
  output logic              inhibit_o,
  output logic              brk_o
);
  logic present;
  logic wp_hit;

  assign present = valid_i && !ent_i.absent;
  assign wp_hit  = present && wr_i && ent_i.wprot;

  always_comb begin
    sel_tgt_o = present && !ent_i.emu;
    sel_emu_o = present && ent_i.emu;
    phys_o    = ent_i.emu ? {ent_i.xlat, addr_i[OFF_W-1:0]} : addr_i;
    // an absent block always suppresses writes and breaks
    inhibit_o = wp_hit || (valid_i && ent_i.absent && wr_i);
    brk_o     = (valid_i && ent_i.absent) || (wp_hit && brk_on_wr_i);
  end
endmodule

// File: rtl/map_rdsel.sv
module map_rdsel #(
  parameter int DATA_W = 8
) (
  input  logic              sel_emu_i,
  input  logic              sel_tgt_i,
  input  logic [DATA_W-1:0] emu_rdata_i,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    if (sel_emu_i)      rdata_o = emu_rdata_i;
    else if (sel_tgt_i) rdata_o = tgt_rdata_i;
    else                rdata_o = '1;
  end
endmodule

// File: rtl/blk_mapper.sv
module blk_mapper
  import mapper_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_we_i,
  input  logic [BLK_W-1:0]  map_idx_i,
  input  logic              map_emu_i,
  input  logic              map_absent_i,
  input  logic              map_wprot_i,
  input  logic [BLK_W-1:0]  map_xlat_i,
  input  logic              brk_on_wr_i,
  input  logic              acc_valid_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] emu_rdata_i,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  output logic              sel_tgt_o,
  output logic              sel_emu_o,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic              wr_inhibit_o,
  output logic              brk_o,
  output logic [DATA_W-1:0] rdata_o
);
  map_ent_t wr_ent;
  map_ent_t cur_ent;

  assign wr_ent = '{emu: map_emu_i, absent: map_absent_i,
                    wprot: map_wprot_i, xlat: map_xlat_i};

  map_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (map_we_i),
    .wr_idx_i (map_idx_i),
    .wr_ent_i (wr_ent),
    .rd_idx_i (acc_addr_i[ADDR_W-1:OFF_W]),
    .rd_ent_o (cur_ent)
  );

  map_check u_check (
    .ent_i       (cur_ent),
    .valid_i     (acc_valid_i),
    .wr_i        (acc_wr_i),
    .brk_on_wr_i (brk_on_wr_i),
    .addr_i      (acc_addr_i),
    .sel_tgt_o   (sel_tgt_o),
    .sel_emu_o   (sel_emu_o),
    .phys_o      (phys_addr_o),
    .inhibit_o   (wr_inhibit_o),
    .brk_o       (brk_o)
  );

  map_rdsel #(.DATA_W(DATA_W)) u_rdsel (
    .sel_emu_i   (sel_emu_o),
    .sel_tgt_i   (sel_tgt_o),
    .emu_rdata_i (emu_rdata_i),
    .tgt_rdata_i (tgt_rdata_i),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/blk_mapper_chk.sv
module blk_mapper_chk
  import mapper_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              brk_on_wr_i,
  input logic              acc_valid_i,
  input logic              acc_wr_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              sel_tgt_o,
  input logic              sel_emu_o,
  input logic [ADDR_W-1:0] phys_addr_o,
  input logic              wr_inhibit_o,
  input logic              brk_o,
  input logic [DATA_W-1:0] rdata_o
);
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !sel_tgt_o && !sel_emu_o && !brk_o && !wr_inhibit_o);

  // R3
  one_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_tgt_o, sel_emu_o}));

  // R4
  tgt_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_tgt_o |-> phys_addr_o == acc_addr_i);

  // R3
  emu_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_emu_o |-> phys_addr_o[OFF_W-1:0] == acc_addr_i[OFF_W-1:0]);

  // R5
  rd_brk_nosel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o && !acc_wr_i |-> !sel_tgt_o && !sel_emu_o && rdata_o == '1);

  // R6
  wr_brk_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o && acc_wr_i |-> wr_inhibit_o);

  // R6
  wp_nobrk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_inhibit_o && !brk_on_wr_i |-> (brk_o == !(sel_tgt_o || sel_emu_o)));
endmodule

bind blk_mapper blk_mapper_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .brk_on_wr_i  (brk_on_wr_i),
  .acc_valid_i  (acc_valid_i),
  .acc_wr_i     (acc_wr_i),
  .acc_addr_i   (acc_addr_i),
  .sel_tgt_o    (sel_tgt_o),
  .sel_emu_o    (sel_emu_o),
  .phys_addr_o  (phys_addr_o),
  .wr_inhibit_o (wr_inhibit_o),
  .brk_o        (brk_o),
  .rdata_o      (rdata_o)
);

// File: tb/blk_mapper_test.sv
module blk_mapper_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        map_we_i = 1'b0;
  logic [5:0]  map_idx_i = '0;
  logic        map_emu_i = 1'b0;
  logic        map_absent_i = 1'b0;
  logic        map_wprot_i = 1'b0;
  logic [5:0]  map_xlat_i = '0;
  logic        brk_on_wr_i = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic        acc_wr_i = 1'b0;
  logic [15:0] acc_addr_i = '0;
  logic [7:0]  emu_rdata_i = '0;
  logic [7:0]  tgt_rdata_i = '0;
  logic        sel_tgt_o, sel_emu_o, wr_inhibit_o, brk_o;
  logic [15:0] phys_addr_o;
  logic [7:0]  rdata_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  blk_mapper uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_map(input int idx, input bit emu, input bit ab, input bit wp, input int xl);
    @(negedge clk_i);
    map_we_i = 1'b1; map_idx_i = 6'(idx); map_emu_i = emu;
    map_absent_i = ab; map_wprot_i = wp; map_xlat_i = 6'(xl);
    @(negedge clk_i);
    map_we_i = 1'b0;
  endtask

  // one access; expectations computed from the requirement table
  task automatic access(input int blk, input bit wr, input bit bow,
                        input bit emu, input bit ab, input bit wp, input int xl);
    logic [15:0] a;
    logic [15:0] ep;
    bit es_t, es_e, ei, eb;
    logic [7:0] ed;
    @(negedge clk_i);
    a = {6'(blk), 10'((blk * 37 + 5) % 1024)};
    acc_valid_i = 1'b1; acc_wr_i = wr; acc_addr_i = a; brk_on_wr_i = bow;
    emu_rdata_i = 8'hA5 ^ 8'(blk); tgt_rdata_i = 8'h3C ^ 8'(blk);
    es_t = !ab && !emu;
    es_e = !ab && emu;
    ep   = emu ? {6'(xl), a[9:0]} : a;
    ei   = wr && (ab || wp);
    eb   = ab || (wr && wp && bow);
    ed   = ab ? 8'hFF : (emu ? 8'hA5 ^ 8'(blk) : 8'h3C ^ 8'(blk));
    #5;
    chk(ab ? "R5 sel" : (emu ? "R3 sel" : "R4 sel"), {sel_tgt_o, sel_emu_o}, {es_t, es_e});
    if (!ab) chk(emu ? "R3 addr" : "R4 addr", phys_addr_o, ep);
    chk(wp && wr ? "R6 inhibit" : (ab ? "R5 inhibit" : "R7 inhibit"), wr_inhibit_o, ei);
    chk(wp && wr ? "R6 brk" : (ab ? "R5 brk" : "R7 brk"), brk_o, eb);
    if (!wr) chk(ab ? "R5 rdata" : "R9 rdata", rdata_o, ed);
  endtask

  function automatic bit p_emu(int b); return b[0]; endfunction
  function automatic bit p_ab(int b);  return (b % 5) == 3; endfunction
  function automatic bit p_wp(int b);  return b[1] ^ b[2]; endfunction
  function automatic int p_xl(int b);  return (b * 7 + 3) % 64; endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset map is identity, target, unprotected
    for (int b = 0; b < 64; b++) access(b, 0, 1, 0, 0, 0, b);
    access(17, 1, 1, 0, 0, 0, 17);
    // R8: idle access
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_wr_i = 1'b1; acc_addr_i = 16'h0400;
    #5;
    chk("R8 idle", {sel_tgt_o, sel_emu_o, wr_inhibit_o, brk_o}, 4'b0);
    // R2: single entry write, neighbours unchanged
    wr_map(9, 1, 0, 0, 40);
    access(9, 0, 0, 1, 0, 0, 40);
    access(8, 0, 0, 0, 0, 0, 8);
    access(10, 1, 0, 0, 0, 0, 10);
    // full load
    for (int b = 0; b < 64; b++) wr_map(b, p_emu(b), p_ab(b), p_wp(b), p_xl(b));
    for (int b = 0; b < 64; b++)
      for (int k = 0; k < 4; k++)
        access(b, k[0], k[1], p_emu(b), p_ab(b), p_wp(b), p_xl(b));
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule